// File: doc/BRIEF.md
# Multiplexed LED Matrix PWM Scanner

This block drives a time-multiplexed LED dot matrix. It has 18 column current-sink enables and up to 4 row scan-switch enables, so it can address 72 dots. The row scan visits only the configured number of lines, from 1 to 4. Each row gets one full PWM period of 256 clock cycles. Between slots there is a 2-cycle blanking gap in which every sink and every scan switch is off.

Each dot has an on/off bit, a group assignment and a brightness value. The brightness value is read as 8 or 16 bits, chosen by a control bit. The dot value, its group value and one global value are multiplied together, each taken as a fraction of full scale. The product is truncated to the 256-step PWM counter. The sinks start their on-time at staggered offsets, so the turn-on current of the channels is spread over the period.

Registers are written through a synchronous byte write port with an address, data and a strobe. Writes go into a shadow bank. The shadow bank is copied into the live bank only in the blanking gap that comes before a row-0 slot. As a result, one scan frame never mixes old settings with new ones.

Top module: `ledmx_scanner`

## Requirements
- R1: While rst_n is low, scan_en and sink_en are all zero. After reset every dot is off and all settings are zero, so no sink is enabled. The first slot after reset belongs to row 0, because the reset value of the line-count field is 0, meaning one line.
- R2: Bits [1:0] of the control byte at address 0x00 give the line count minus one. Slots visit rows 0 up to that count in ascending order and then wrap to row 0. During the slot of row r, scan_en has only bit r set.
- R3: A slot lasts exactly 256 cycles with a constant scan_en. Slots are separated by exactly 2 cycles in which scan_en and sink_en are both zero.
- R4: Dot i is the dot at row r and column c, with i = r*18 + c. Its on bit is bit i%8 of the byte at address 0x10 + i/8. A dot whose on bit is clear never enables its sink, whatever its brightness settings.
- R5: The global value is written at address 0x01 and the three group values at 0x02, 0x03 and 0x04. The group code of dot i is bits [2*(i%4)+1 : 2*(i%4)] of the byte at address 0x20 + i/4. Codes 0, 1 and 2 select groups 0, 1 and 2, and code 3 also selects group 2. The duty is floor(dot * group * global * 256 / (dmax * 255 * 255)).
- R6: The low byte of dot i is at address 0x40 + i and the high byte at address 0x90 + i. When control bit 2 is set, the dot value is 16 bits and dmax is 65535. When it is clear, only the low byte counts, the high byte has no effect, and dmax is 255.
- R7: Let k be the cycle index within the slot (0 to 255). Column n is enabled when ((k - floor(n*256/18)) mod 256) < duty. This gives each column a staggered start, and its on-time is exactly duty cycles long.
- R8: A duty of 0 keeps the sink off for the whole slot. A duty of 256 keeps it on for all 256 cycles of the slot.
- R9: Writes reach the outputs only from the next row-0 slot onward. Slots that are still left in the current frame keep the settings that were loaded at the start of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 8 | Write data byte |
| sink_en | output | 18 | Column current-sink enables |
| scan_en | output | 4 | Row scan-switch enables, one-hot during a slot |

## Verification
Two events can fall in the same cycle: a register write, and the copy of the shadow bank into the live bank at a frame boundary. A second overlap is a column whose on-window wraps past the end of the period inside a single slot. The bench writes new dot values while row 1 of a three-line frame is being scanned. It then requires row 2 of that frame to show the old pattern and the following row-0 slot to show the new one. Every slot is compared cycle by cycle against offsets and duties computed from the formulas. This covers high-index columns whose on-time wraps around k = 0.

// File: rtl/ledmx_pkg.sv
// Package: shared constants of the LED matrix scanner.
// Assumes an 8-bit byte write port; the address bases below decode in ledmx_regs.
package ledmx_pkg;
    localparam int unsigned ADDR_W    = 8;
    localparam int unsigned DATA_W    = 8;
    localparam int unsigned DOT_W     = 16;
    localparam int unsigned ADDR_CTRL = 8'h00;
    localparam int unsigned ADDR_GLOB = 8'h01;
    localparam int unsigned ADDR_GRP  = 8'h02;
    localparam int unsigned BASE_ON   = 8'h10;
    localparam int unsigned BASE_MAP  = 8'h20;
    localparam int unsigned BASE_LO   = 8'h40;
    localparam int unsigned BASE_HI   = 8'h90;
    localparam int unsigned NUM_GRP   = 3;
endpackage

// File: rtl/ledmx_regs.sv
// Module: shadow and live register banks.
// Byte writes land in the shadow bank; the live bank copies the shadow bank
// when frame_load pulses. Assumes NUM_DOTS addresses fit below each next base.
module ledmx_regs
    import ledmx_pkg::*;
#(
    parameter int NUM_DOTS = 72,
    parameter int ROW_W    = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [DATA_W-1:0]               wr_data,
    input  logic                            frame_load,
    output logic [NUM_DOTS-1:0]             act_on,
    output logic [NUM_DOTS-1:0][1:0]        act_map,
    output logic [NUM_DOTS-1:0][DOT_W-1:0]  act_dot,
    output logic [7:0]                      act_glob,
    output logic [NUM_GRP-1:0][7:0]         act_grp,
    output logic [ROW_W-1:0]                act_lines,
    output logic                            act_wide
);
    logic [NUM_DOTS-1:0]            sh_on;
    logic [NUM_DOTS-1:0][1:0]       sh_map;
    logic [NUM_DOTS-1:0][DOT_W-1:0] sh_dot;
    logic [7:0]                     sh_glob;
    logic [NUM_GRP-1:0][7:0]        sh_grp;
    logic [ROW_W-1:0]               sh_lines;
    logic                           sh_wide;

    // Decode byte writes into the shadow bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_on    <= '0;
            sh_map   <= '0;
            sh_dot   <= '0;
            sh_glob  <= '0;
            sh_grp   <= '0;
            sh_lines <= '0;
            sh_wide  <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(ADDR_CTRL)) begin
                sh_lines <= wr_data[ROW_W-1:0];
                sh_wide  <= wr_data[2];
            end
            if (wr_addr == ADDR_W'(ADDR_GLOB))
                sh_glob <= wr_data;
            for (int g = 0; g < NUM_GRP; g++) begin
                if (wr_addr == ADDR_W'(ADDR_GRP + g))
                    sh_grp[g] <= wr_data;
            end
            for (int i = 0; i < NUM_DOTS; i++) begin
                if (wr_addr == ADDR_W'(BASE_ON + i / 8))
                    sh_on[i] <= wr_data[i % 8];
                if (wr_addr == ADDR_W'(BASE_MAP + i / 4))
                    sh_map[i] <= wr_data[2 * (i % 4) +: 2];
                if (wr_addr == ADDR_W'(BASE_LO + i))
                    sh_dot[i][7:0] <= wr_data;
                if (wr_addr == ADDR_W'(BASE_HI + i))
                    sh_dot[i][15:8] <= wr_data;
            end
        end
    end

    // Copy the whole shadow bank into the live bank at a frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_on    <= '0;
            act_map   <= '0;
            act_dot   <= '0;
            act_glob  <= '0;
            act_grp   <= '0;
            act_lines <= '0;
            act_wide  <= 1'b0;
        end else if (frame_load) begin
            act_on    <= sh_on;
            act_map   <= sh_map;
            act_dot   <= sh_dot;
            act_glob  <= sh_glob;
            act_grp   <= sh_grp;
            act_lines <= sh_lines;
            act_wide  <= sh_wide;
        end
    end
endmodule

// File: rtl/ledmx_seq.sv
// Module: scan sequencer.
// Runs blanking (BLANK_CYC cycles) then one PWM period per row, and visits
// rows 0..lines_act before wrapping. frame_load pulses on the last blanking
// cycle ahead of row 0. Assumes BLANK_CYC >= 1.
module ledmx_seq #(
    parameter int CNT_W     = 8,
    parameter int ROW_W     = 2,
    parameter int BLANK_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROW_W-1:0] lines_act,
    output logic [ROW_W-1:0] row_idx,
    output logic             in_blank,
    output logic [CNT_W-1:0] pwm_cnt,
    output logic             frame_load
);
    localparam int BW = $clog2(BLANK_CYC + 1);
    localparam logic [BW-1:0]    BLANK_LAST = BW'(BLANK_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_LAST   = '1;

    logic [BW-1:0] blank_cnt;

    // Step through blanking, the PWM period and the row index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_idx   <= '0;
            in_blank  <= 1'b1;
            blank_cnt <= '0;
            pwm_cnt   <= '0;
        end else if (in_blank) begin
            if (blank_cnt == BLANK_LAST) begin
                in_blank <= 1'b0;
                pwm_cnt  <= '0;
            end else begin
                blank_cnt <= blank_cnt + 1'b1;
            end
        end else if (pwm_cnt == CNT_LAST) begin
            in_blank  <= 1'b1;
            blank_cnt <= '0;
            row_idx   <= (row_idx >= lines_act) ? '0 : row_idx + 1'b1;
        end else begin
            pwm_cnt <= pwm_cnt + 1'b1;
        end
    end

    // Frame boundary: last blanking cycle before a row-0 slot.
    assign frame_load = in_blank && (blank_cnt == BLANK_LAST) && (row_idx == '0);
endmodule

// File: rtl/ledmx_duty.sv
// Module: brightness composer for one column.
// Computes floor(dot*grp*glob*2^CNT_W / (dmax*255*255)), where dmax depends on
// the 8/16-bit mode. Purely combinational; forced to zero when the dot is off.
module ledmx_duty #(
    parameter int CNT_W = 8
) (
    input  logic             dot_on,
    input  logic             wide,
    input  logic [15:0]      dot_val,
    input  logic [7:0]       grp_val,
    input  logic [7:0]       glob_val,
    output logic [CNT_W:0]   duty
);
    localparam logic [63:0] DEN_NARROW = 64'd255 * 64'd65025;
    localparam logic [63:0] DEN_WIDE   = 64'd65535 * 64'd65025;

    logic [63:0] prod;
    logic [63:0] quot;

    // Multiply the three fractions and truncate to the counter resolution.
    always_comb begin
        prod = (wide ? 64'(dot_val) : 64'(dot_val[7:0])) * 64'(grp_val) * 64'(glob_val);
        quot = (prod << CNT_W) / (wide ? DEN_WIDE : DEN_NARROW);
        duty = dot_on ? quot[CNT_W:0] : '0;
    end
endmodule

// File: rtl/ledmx_scanner.sv
// Module: top of the multiplexed LED matrix PWM scanner.
// Combines the register banks, the scan sequencer and one composer and
// comparator per column. Column c starts its on-time at c*PERIOD/NUM_COLS.
// Outputs are registered, so they follow the sequencer state by one cycle.
module ledmx_scanner
    import ledmx_pkg::*;
#(
    parameter int NUM_COLS  = 18,
    parameter int NUM_ROWS  = 4,
    parameter int CNT_W     = 8,
    parameter int BLANK_CYC = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [7:0]          wr_addr,
    input  logic [7:0]          wr_data,
    output logic [NUM_COLS-1:0] sink_en,
    output logic [NUM_ROWS-1:0] scan_en
);
    localparam int NUM_DOTS = NUM_COLS * NUM_ROWS;
    localparam int ROW_W    = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;
    localparam int IDX_W    = $clog2(NUM_DOTS);
    localparam int PERIOD   = 1 << CNT_W;

    logic [NUM_DOTS-1:0]            act_on;
    logic [NUM_DOTS-1:0][1:0]       act_map;
    logic [NUM_DOTS-1:0][DOT_W-1:0] act_dot;
    logic [7:0]                     act_glob;
    logic [NUM_GRP-1:0][7:0]        act_grp;
    logic [ROW_W-1:0]               act_lines;
    logic                           act_wide;
    logic [ROW_W-1:0]               row_idx;
    logic                           in_blank;
    logic [CNT_W-1:0]               pwm_cnt;
    logic                           frame_load;
    logic [NUM_COLS-1:0]            lit;

    ledmx_regs #(.NUM_DOTS(NUM_DOTS), .ROW_W(ROW_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .frame_load (frame_load),
        .act_on     (act_on),
        .act_map    (act_map),
        .act_dot    (act_dot),
        .act_glob   (act_glob),
        .act_grp    (act_grp),
        .act_lines  (act_lines),
        .act_wide   (act_wide)
    );

    ledmx_seq #(.CNT_W(CNT_W), .ROW_W(ROW_W), .BLANK_CYC(BLANK_CYC)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .lines_act  (act_lines),
        .row_idx    (row_idx),
        .in_blank   (in_blank),
        .pwm_cnt    (pwm_cnt),
        .frame_load (frame_load)
    );

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        localparam logic [CNT_W-1:0] OFFSET = CNT_W'((c * PERIOD) / NUM_COLS);

        logic [IDX_W-1:0] idx;
        logic [7:0]       grp_val;
        logic [CNT_W:0]   duty;
        logic [CNT_W-1:0] phase;

        // Pick the dot of this column in the current row and its group value.
        always_comb begin
            idx = IDX_W'(int'(row_idx) * NUM_COLS + c);
            case (act_map[idx])
                2'd0:    grp_val = act_grp[0];
                2'd1:    grp_val = act_grp[1];
                default: grp_val = act_grp[2];
            endcase
        end

        ledmx_duty #(.CNT_W(CNT_W)) u_duty (
            .dot_on   (act_on[idx]),
            .wide     (act_wide),
            .dot_val  (act_dot[idx]),
            .grp_val  (grp_val),
            .glob_val (act_glob),
            .duty     (duty)
        );

        // Shift the counter by this column's offset and compare it with the duty.
        always_comb begin
            phase  = pwm_cnt - OFFSET;
            lit[c] = !in_blank && ({1'b0, phase} < duty);
        end
    end

    // Register the sink and scan enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sink_en <= '0;
            scan_en <= '0;
        end else begin
            sink_en <= lit;
            scan_en <= in_blank ? '0 : (NUM_ROWS'(1) << row_idx);
        end
    end
endmodule

// File: rtl/ledmx_scanner_chk.sv
// Module: property checker for ledmx_scanner, attached with bind.
// Watches the enables and the live line count. A counter measures slot length.
module ledmx_scanner_chk #(
    parameter int NUM_COLS = 18,
    parameter int NUM_ROWS = 4,
    parameter int ROW_W    = 2,
    parameter int CNT_W    = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_COLS-1:0] sink_en,
    input logic [NUM_ROWS-1:0] scan_en,
    input logic [ROW_W-1:0]    act_lines
);
    localparam logic [CNT_W:0] PERIOD = (CNT_W+1)'(1) << CNT_W;

    logic [CNT_W:0] run_len;

    // Count how many cycles in a row scan_en has been nonzero.
    always_ff @(posedge clk) begin
        if (!rst_n)            run_len <= '0;
        else if (scan_en != '0) run_len <= run_len + 1'b1;
        else                   run_len <= '0;
    end

    // R2
    scan_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(scan_en));

    // R2
    scan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en != '0) |-> ({1'b0, scan_en} < ((NUM_ROWS+1)'(2) << act_lines)));

    // R3
    blank_sink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en == '0) |-> (sink_en == '0));

    // R3
    blank_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(scan_en) != '0 && scan_en == '0) |=> (scan_en == '0));

    // R3
    slot_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(scan_en) != '0 && scan_en == '0) |-> (run_len == PERIOD));

    // R3
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(scan_en) != '0 && scan_en != '0) |-> $stable(scan_en));
endmodule

bind ledmx_scanner ledmx_scanner_chk #(
    .NUM_COLS (NUM_COLS),
    .NUM_ROWS (NUM_ROWS),
    .ROW_W    (ROW_W),
    .CNT_W    (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sink_en   (sink_en),
    .scan_en   (scan_en),
    .act_lines (act_lines)
);

// File: tb/test_ledmx_scanner.sv
// Directed bench for ledmx_scanner: a write model plus a per-slot comparison
// of every cycle against duties and offsets derived from the requirements.
module test_ledmx_scanner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [17:0] sink_en;
    logic [3:0]  scan_en;

    int checks = 0;
    int fails  = 0;

    // Shadow model (what was written) and applied model (what the frame uses).
    int m_on[72], m_map[72], m_val[72], m_glob, m_g[3], m_ctrl;
    int a_on[72], a_map[72], a_val[72], a_glob, a_g[3], a_ctrl;

    ledmx_scanner i_ledmx_scanner (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sink_en (sink_en),
        .scan_en (scan_en)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_ctrl(input int v); m_ctrl = v; wr(8'h00, v); endtask
    task automatic set_glob(input int v); m_glob = v; wr(8'h01, v); endtask
    task automatic set_grp(input int g, input int v); m_g[g] = v; wr(8'h02 + g, v); endtask

    task automatic set_dot(input int r, input int c, input int val, input int on, input int map);
        int i, ob, mb;
        i = r * 18 + c;
        m_on[i] = on; m_map[i] = map; m_val[i] = val;
        ob = 0; mb = 0;
        for (int b = 0; b < 8; b++) if ((i/8)*8 + b < 72) ob |= m_on[(i/8)*8 + b] << b;
        for (int b = 0; b < 4; b++) mb |= m_map[(i/4)*4 + b] << (2*b);
        wr(8'h10 + i/8, ob);
        wr(8'h20 + i/4, mb);
        wr(8'h40 + i, val & 255);
        wr(8'h90 + i, (val >> 8) & 255);
    endtask

    task automatic apply_model();
        a_on = m_on; a_map = m_map; a_val = m_val;
        a_glob = m_glob; a_g = m_g; a_ctrl = m_ctrl;
    endtask

    function automatic int exp_duty(input int i);
        int code, dv, dmax;
        if (a_on[i] == 0) return 0;
        code = (a_map[i] > 2) ? 2 : a_map[i];
        dv   = a_ctrl[2] ? a_val[i] : (a_val[i] & 255);
        dmax = a_ctrl[2] ? 65535 : 255;
        return int'((longint'(dv) * a_g[code] * a_glob * 256) / (longint'(dmax) * 65025));
    endfunction

    function automatic logic [17:0] exp_cols(input int r, input int k);
        logic [17:0] v;
        for (int n = 0; n < 18; n++) begin
            int ph;
            ph = (((k - (n * 256) / 18) % 256) + 256) % 256;
            v[n] = exp_duty(r * 18 + n) > ph;
        end
        return v;
    endfunction

    // Wait until scan_en turns from zero to row r (seen at a falling edge).
    task automatic wait_start(input int r);
        logic [3:0] prev;
        prev = scan_en;
        @(negedge clk);
        while (!(prev == 4'h0 && scan_en == 4'(1 << r))) begin
            prev = scan_en;
            @(negedge clk);
        end
    endtask

    // Compare one whole slot of row r, then its blanking gap.
    task automatic check_slot(input int r, input string tag);
        int bad, bk;
        logic [17:0] ea, ee;
        wait_start(r);
        bad = 0; bk = -1; ea = '0; ee = '0;
        for (int k = 0; k < 256; k++) begin
            logic [17:0] e;
            e = exp_cols(r, k);
            if (sink_en !== e || scan_en !== 4'(1 << r)) begin
                if (bad == 0) begin bk = k; ea = sink_en; ee = e; end
                bad++;
            end
            @(negedge clk);
        end
        check(bad == 0, tag, $sformatf("row %0d first bad cycle %0d sink", r, bk), int'(ea), int'(ee));
        bad = 0;
        for (int b = 0; b < 2; b++) begin
            if (scan_en !== 4'h0 || sink_en !== 18'h0) bad++;
            if (b < 1) @(negedge clk);
        end
        check(bad == 0, "R3", $sformatf("blank after row %0d bad cycles", r), bad, 0);
    endtask

    task automatic check_frame(input string tag);
        for (int r = 0; r <= (a_ctrl & 3); r++) check_slot(r, tag);
    endtask

    // Write, let the current frame pass, then expect the new values.
    task automatic commit();
        wait_start(0);
        apply_model();
    endtask

    task automatic t_reset();
        repeat (5) @(negedge clk);
        check(scan_en === 4'h0 && sink_en === 18'h0, "R1", "outputs in reset",
              int'({scan_en, sink_en}), 0);
        rst_n = 1'b1;
        apply_model();
        check_slot(0, "R1");
    endtask

    task automatic t_full_zero_off();
        set_glob(255); set_grp(0, 255);
        set_dot(0, 0, 255, 1, 0);
        set_dot(0, 1, 0, 1, 0);
        set_dot(0, 2, 255, 0, 0);
        commit();
        check_frame("R8");
        check_frame("R4");
    endtask

    task automatic t_phase();
        for (int c = 0; c < 18; c++) set_dot(0, c, 128, 1, 0);
        set_dot(0, 16, 255, 1, 0);
        set_dot(0, 17, 40, 1, 0);
        commit();
        check_frame("R7");
    endtask

    task automatic t_groups();
        set_glob(200); set_grp(1, 100); set_grp(2, 50);
        set_dot(0, 0, 255, 1, 1);
        set_dot(0, 1, 200, 1, 2);
        set_dot(0, 2, 255, 1, 3);
        set_dot(0, 3, 255, 1, 0);
        commit();
        check_frame("R5");
    endtask

    task automatic t_width();
        set_glob(255); set_grp(0, 255);
        set_dot(0, 3, 16'h8000, 1, 0);
        set_dot(0, 4, 16'h00FF, 1, 0);
        set_ctrl(4);
        commit();
        check_frame("R6");
        set_ctrl(0);
        commit();
        check_frame("R6");
    endtask

    task automatic t_lines();
        set_dot(1, 7, 255, 1, 0);
        set_dot(2, 17, 90, 1, 0);
        set_ctrl(2);
        commit();
        check_frame("R2");
        @(negedge clk);
        check(scan_en === 4'h1, "R2", "row after wrap of 3 lines", int'(scan_en), 1);
        set_dot(3, 9, 255, 1, 0);
        set_ctrl(3);
        commit();
        check_frame("R2");
    endtask

    task automatic t_tear();
        set_ctrl(2);
        commit();
        check_frame("R9");
        wait_start(1);
        set_dot(2, 17, 200, 1, 0);
        set_dot(1, 7, 0, 1, 0);
        set_dot(0, 0, 30, 1, 0);
        check_slot(2, "R9");
        apply_model();
        check_frame("R9");
    endtask

    initial begin
        for (int i = 0; i < 72; i++) begin m_on[i] = 0; m_map[i] = 0; m_val[i] = 0; end
        m_glob = 0; m_ctrl = 0;
        for (int g = 0; g < 3; g++) m_g[g] = 0;
        t_reset();
        t_full_zero_off();
        t_phase();
        t_groups();
        t_width();
        t_lines();
        t_tear();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule